// File: doc/BRIEF.md
# Frame-Synchronous Video Stream Crossbar

This block connects a set of video source streams to a set of video sink streams. Each stream carries pixels with a valid/ready handshake. It also carries a start-of-frame flag and an end-of-frame flag. Software configures the routing through a small word-addressed register port. For every sink it writes a one-hot pick of the source that should feed it. Those picks are only staged. They reach the datapath when software requests a commit, and then only once the streams involved sit between frames. This means no frame is ever cut or spliced.

When the new routing takes hold, a completion flag is set, and an enabled interrupt line follows it. A source that feeds no sink is, by choice, either held off or drained with its data thrown away. One source may feed several sinks at once. Each of its pixels then moves only when every sink it feeds can take it. A run/stop control lets frames in progress drain before the block goes quiet.

Top module: `vsx_crossbar`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and no `src_ready` or `dst_valid` is asserted, whatever the sources present.
- R2: Word 0 holds the run bit (bit 0) and the interrupt enable (bit 1), read back as `{enable, run}`. Word 1 bit 0 reads 1 from the second clock edge after run is written 1, and all its other bits read 0.
- R3: Word 4+k holds the staged source pick for sink k, with bit i naming source i. Writing it changes no routing until a commit, and it reads back as written.
- R4: Writing 1 to bit 0 of word 3 requests a commit. The staged picks go live at the first clock edge at which no sink is inside a frame and no source used by the staged picks is inside a frame. While a commit waits, frames already open keep flowing, and no idle sink starts a new frame.
- R5: Word 2 bit 0 is set at the same edge the new routing goes live. Writing 1 to that bit clears it. `irq` equals that bit ANDed with the enable.
- R6: A sink whose live pick names source i shows that source's data, start and end flags, and valid, and that source's ready follows the sink's ready.
- R7: A source picked by several sinks raises ready only when all of them are ready. Each of those sinks raises valid only when all the others are ready, so every pixel reaches each sink exactly once.
- R8: A pick with more than one bit set goes live as no source. A sink with no source keeps `dst_valid` low.
- R9: Word 16 bit i (reset 0) selects the treatment of unpicked source i: 1 asserts its ready while running and drops its data, 0 holds its ready low.
- R10: After run is cleared, frames already open finish, and no new frame starts. Status drops to 0 one edge after the last open frame's end transfer. Once stopped, no ready or valid is raised.
- R11: Words with no register behind them, including pick words for sinks at or above the sink count, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | 5 | Register word address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid in the same cycle as `cfg_rd` |
| irq | output | 1 | Routing-change interrupt |
| src_data | input | N_IN*DW | Source pixel data, source i in slice i |
| src_valid | input | N_IN | Source valid |
| src_sof | input | N_IN | Source start-of-frame flag |
| src_eof | input | N_IN | Source end-of-frame flag |
| src_ready | output | N_IN | Source ready |
| dst_data | output | N_OUT*DW | Sink pixel data, sink k in slice k |
| dst_valid | output | N_OUT | Sink valid |
| dst_sof | output | N_OUT | Sink start-of-frame flag |
| dst_eof | output | N_OUT | Sink end-of-frame flag |
| dst_ready | input | N_OUT | Sink ready |

## Verification
The stream path has no registers in it, so sink valid, data and source ready are sampled in the same cycle the stimulus is applied. Register writes land at the next edge, and read data is combinational. A commit waits one edge in a pending register, so live routing and the interrupt bit are checked at the second edge after the write edge. When a frame is open, they are checked one edge after that frame's end transfer, and the bench also checks that they have not changed one cycle earlier. The status bit is sampled both at the edge after the last end transfer, where it must still be 1, and one edge later, where it must be 0. All sampling happens at the falling clock edge.

// File: rtl/vsx_pkg.sv
`timescale 1ns/1ps
package vsx_pkg;
   localparam int REG_AW  = 5;
   localparam int REG_DW  = 32;
   localparam int MAX_OUT = 12;
   localparam int MAX_IN  = 32;

   localparam logic [REG_AW-1:0] W_CTRL   = 5'd0;
   localparam logic [REG_AW-1:0] W_STAT   = 5'd1;
   localparam logic [REG_AW-1:0] W_IRQ    = 5'd2;
   localparam logic [REG_AW-1:0] W_COMMIT = 5'd3;
   localparam logic [REG_AW-1:0] W_PICK0  = 5'd4;
   localparam logic [REG_AW-1:0] W_DRAIN  = 5'd16;
endpackage

// File: rtl/vsx_regs.sv
`timescale 1ns/1ps
module vsx_regs
   import vsx_pkg::*;
#(
   parameter int N_IN  = 3,
   parameter int N_OUT = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [REG_AW-1:0]              addr,
   input  logic                           wr,
   input  logic                           rd,
   input  logic [REG_DW-1:0]              wdata,
   output logic [REG_DW-1:0]              rdata,
   input  logic                           running,
   input  logic                           irq_st,
   output logic                           run_bit,
   output logic                           irq_en,
   output logic [N_OUT-1:0][N_IN-1:0]     stage_pick,
   output logic [N_IN-1:0]                drain_en,
   output logic                           commit_req,
   output logic                           irq_clr
);
   logic unused_wdata;
   assign unused_wdata = &{1'b0, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_bit    <= 1'b0;
         irq_en     <= 1'b0;
         stage_pick <= '0;
         drain_en   <= '0;
      end else if (wr) begin
         if (addr == W_CTRL) begin
            run_bit <= wdata[0];
            irq_en  <= wdata[1];
         end
         if (addr == W_DRAIN) drain_en <= wdata[N_IN-1:0];
         for (int k = 0; k < N_OUT; k++) begin
            if (int'(addr) == int'(W_PICK0) + k) stage_pick[k] <= wdata[N_IN-1:0];
         end
      end
   end

   assign commit_req = wr && (addr == W_COMMIT) && wdata[0];
   assign irq_clr    = wr && (addr == W_IRQ) && wdata[0];

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            W_CTRL:  rdata[1:0] = {irq_en, run_bit};
            W_STAT:  rdata[0] = running;
            W_IRQ:   rdata[0] = irq_st;
            W_DRAIN: rdata[N_IN-1:0] = drain_en;
            default: begin
               for (int k = 0; k < N_OUT; k++) begin
                  if (int'(addr) == int'(W_PICK0) + k) rdata[N_IN-1:0] = stage_pick[k];
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/vsx_commit.sv
`timescale 1ns/1ps
module vsx_commit #(
   parameter int N_IN  = 3,
   parameter int N_OUT = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_bit,
   input  logic                        commit_req,
   input  logic                        irq_clr,
   input  logic [N_OUT-1:0][N_IN-1:0]  stage_pick,
   input  logic [N_IN-1:0]             src_xfer,
   input  logic [N_IN-1:0]             src_eof,
   input  logic [N_OUT-1:0]            dst_xfer,
   input  logic [N_OUT-1:0]            dst_eof,
   output logic [N_OUT-1:0][N_IN-1:0]  live_pick,
   output logic [N_OUT-1:0]            dst_gate,
   output logic [N_IN-1:0]             drain_gate,
   output logic                        running,
   output logic                        irq_st
);
   logic [N_OUT-1:0]           dst_open;
   logic [N_IN-1:0]            src_open;
   logic                       pend;
   logic [N_OUT-1:0][N_IN-1:0] clean_pick;
   logic [N_IN-1:0]            used_src;
   logic                       quiet, apply, admit_new;

   // illegal picks (more than one bit) become "no source"
   always_comb begin
      used_src = '0;
      for (int k = 0; k < N_OUT; k++) begin
         clean_pick[k] = ($countones(stage_pick[k]) == 1) ? stage_pick[k] : '0;
         used_src     |= clean_pick[k];
      end
   end

   assign quiet     = ~|dst_open && ~|(src_open & used_src);
   assign apply     = pend && quiet;
   assign admit_new = run_bit && !pend;

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_dst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           dst_open[k] <= 1'b0;
            else if (dst_xfer[k]) dst_open[k] <= !dst_eof[k];
         end
         assign dst_gate[k] = running && (admit_new || dst_open[k]);

         // R4
         live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dst_open[k] |=> $stable(live_pick[k]));
      end
      for (genvar i = 0; i < N_IN; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           src_open[i] <= 1'b0;
            else if (src_xfer[i]) src_open[i] <= !src_eof[i];
         end
         assign drain_gate[i] = running && (admit_new || src_open[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         live_pick <= '0;
         irq_st    <= 1'b0;
         running   <= 1'b0;
      end else begin
         if (commit_req) pend <= 1'b1;
         else if (apply) pend <= 1'b0;
         if (apply) live_pick <= clean_pick;
         if (apply)        irq_st <= 1'b1;
         else if (irq_clr) irq_st <= 1'b0;
         running <= run_bit || (running && (|dst_open || |src_open));
      end
   end

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_st) |-> $past(pend));
endmodule

// File: rtl/vsx_route.sv
`timescale 1ns/1ps
module vsx_route #(
   parameter int N_IN  = 3,
   parameter int N_OUT = 4,
   parameter int DW    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_OUT-1:0][N_IN-1:0]  live_pick,
   input  logic [N_OUT-1:0]            dst_gate,
   input  logic [N_IN-1:0]             drain_gate,
   input  logic [N_IN-1:0]             drain_en,
   input  logic [N_IN*DW-1:0]          src_data,
   input  logic [N_IN-1:0]             src_valid,
   input  logic [N_IN-1:0]             src_sof,
   input  logic [N_IN-1:0]             src_eof,
   output logic [N_IN-1:0]             src_ready,
   output logic [N_OUT*DW-1:0]         dst_data,
   output logic [N_OUT-1:0]            dst_valid,
   output logic [N_OUT-1:0]            dst_sof,
   output logic [N_OUT-1:0]            dst_eof,
   input  logic [N_OUT-1:0]            dst_ready
);
   typedef logic [N_OUT-1:0] omask_t;

   logic [N_IN-1:0][N_OUT-1:0] fanout;
   omask_t                     leg_ok;
   logic [N_IN-1:0]            picked;

   assign leg_ok = dst_ready & dst_gate;

   always_comb begin
      for (int i = 0; i < N_IN; i++)
         for (int k = 0; k < N_OUT; k++)
            fanout[i][k] = live_pick[k][i];
   end

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_src
         assign picked[i]    = |fanout[i];
         assign src_ready[i] = picked[i] ? &(~fanout[i] | leg_ok)
                                         : (drain_en[i] && drain_gate[i]);

         // R7
         fanout_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_valid[i] && src_ready[i] && picked[i]) |->
               ((fanout[i] & dst_valid & dst_ready) == fanout[i]));
         // R9
         drain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_ready[i] && !picked[i]) |-> drain_en[i]);
      end

      for (genvar k = 0; k < N_OUT; k++) begin : g_dst
         localparam omask_t SELF_M = omask_t'(1) << k;
         logic          v, s, e;
         logic [DW-1:0] d;

         always_comb begin
            v = 1'b0;
            s = 1'b0;
            e = 1'b0;
            d = '0;
            for (int i = 0; i < N_IN; i++) begin
               if (live_pick[k][i]) begin
                  v = src_valid[i] && dst_gate[k] && (&(~fanout[i] | leg_ok | SELF_M));
                  s = src_sof[i];
                  e = src_eof[i];
                  d = src_data[i*DW +: DW];
               end
            end
         end

         assign dst_valid[k]           = v;
         assign dst_sof[k]             = s;
         assign dst_eof[k]             = e;
         assign dst_data[k*DW +: DW]   = d;

         // R6
         valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dst_valid[k] |-> (|(live_pick[k] & src_valid)));
      end
   endgenerate
endmodule

// File: rtl/vsx_crossbar.sv
`timescale 1ns/1ps
module vsx_crossbar
   import vsx_pkg::*;
#(
   parameter int N_IN  = 3,
   parameter int N_OUT = 4,
   parameter int DW    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_AW-1:0]     cfg_addr,
   input  logic                  cfg_wr,
   input  logic                  cfg_rd,
   input  logic [REG_DW-1:0]     cfg_wdata,
   output logic [REG_DW-1:0]     cfg_rdata,
   output logic                  irq,
   input  logic [N_IN*DW-1:0]    src_data,
   input  logic [N_IN-1:0]       src_valid,
   input  logic [N_IN-1:0]       src_sof,
   input  logic [N_IN-1:0]       src_eof,
   output logic [N_IN-1:0]       src_ready,
   output logic [N_OUT*DW-1:0]   dst_data,
   output logic [N_OUT-1:0]      dst_valid,
   output logic [N_OUT-1:0]      dst_sof,
   output logic [N_OUT-1:0]      dst_eof,
   input  logic [N_OUT-1:0]      dst_ready
);
   generate
      if (N_OUT < 1 || N_OUT > MAX_OUT) begin : g_bad_out
         $error("vsx_crossbar: N_OUT out of range");
      end
      if (N_IN < 1 || N_IN > MAX_IN) begin : g_bad_in
         $error("vsx_crossbar: N_IN out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("vsx_crossbar: DW must be positive");
      end
   endgenerate

   logic                       run_bit, irq_en, commit_req, irq_clr, running, irq_st;
   logic [N_OUT-1:0][N_IN-1:0] stage_pick, live_pick;
   logic [N_IN-1:0]            drain_en, drain_gate;
   logic [N_OUT-1:0]           dst_gate;

   vsx_regs #(.N_IN(N_IN), .N_OUT(N_OUT)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wr(cfg_wr), .rd(cfg_rd),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .running(running), .irq_st(irq_st),
      .run_bit(run_bit), .irq_en(irq_en), .stage_pick(stage_pick),
      .drain_en(drain_en), .commit_req(commit_req), .irq_clr(irq_clr)
   );

   vsx_commit #(.N_IN(N_IN), .N_OUT(N_OUT)) u_commit (
      .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .commit_req(commit_req),
      .irq_clr(irq_clr), .stage_pick(stage_pick),
      .src_xfer(src_valid & src_ready), .src_eof(src_eof),
      .dst_xfer(dst_valid & dst_ready), .dst_eof(dst_eof),
      .live_pick(live_pick), .dst_gate(dst_gate), .drain_gate(drain_gate),
      .running(running), .irq_st(irq_st)
   );

   vsx_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_route (
      .clk(clk), .rst_n(rst_n), .live_pick(live_pick), .dst_gate(dst_gate),
      .drain_gate(drain_gate), .drain_en(drain_en), .src_data(src_data),
      .src_valid(src_valid), .src_sof(src_sof), .src_eof(src_eof),
      .src_ready(src_ready), .dst_data(dst_data), .dst_valid(dst_valid),
      .dst_sof(dst_sof), .dst_eof(dst_eof), .dst_ready(dst_ready)
   );

   assign irq = irq_st && irq_en;

   // R10
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (dst_valid == '0 && src_ready == '0));
endmodule

// File: tb/vsx_crossbar_test.sv
`timescale 1ns/1ps
module vsx_crossbar_test;
   localparam int NI = 3;
   localparam int NO = 4;
   localparam int DW = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [4:0]        cfg_addr;
   logic              cfg_wr, cfg_rd;
   logic [31:0]       cfg_wdata, cfg_rdata;
   logic              irq;
   logic [NI*DW-1:0]  src_data;
   logic [NI-1:0]     src_valid, src_sof, src_eof, src_ready;
   logic [NO*DW-1:0]  dst_data;
   logic [NO-1:0]     dst_valid, dst_sof, dst_eof, dst_ready;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   vsx_crossbar #(.N_IN(NI), .N_OUT(NO), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
      .src_data(src_data), .src_valid(src_valid), .src_sof(src_sof), .src_eof(src_eof),
      .src_ready(src_ready), .dst_data(dst_data), .dst_valid(dst_valid),
      .dst_sof(dst_sof), .dst_eof(dst_eof), .dst_ready(dst_ready)
   );

   // fields: [25:14] picks {k3,k2,k1,k0}, [13:11] src_valid, [10:7] dst_ready,
   //         [6:3] expected dst_valid, [2:0] expected src_ready
   localparam logic [25:0] VEC [6] = '{
      {12'b000_100_010_001, 3'b111, 4'b1111, 4'b0111, 3'b111},
      {12'b010_000_001_001, 3'b011, 4'b1101, 4'b1010, 3'b010},
      {12'b000_000_100_011, 3'b111, 4'b1111, 4'b0010, 3'b100},
      {12'b100_100_100_100, 3'b100, 4'b1111, 4'b1111, 3'b100},
      {12'b000_001_000_010, 3'b001, 4'b0000, 4'b0100, 3'b000},
      {12'b000_000_000_000, 3'b111, 4'b1111, 4'b0000, 3'b000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [4:0] a, output logic [31:0] d);
      cfg_addr = a; cfg_rd = 1'b1;
      #1 d = cfg_rdata;
      cfg_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      logic [31:0] r;
      rst_n = 1'b0; cfg_addr = '0; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_wdata = '0;
      src_data = {8'hA2, 8'hA1, 8'hA0};
      src_valid = '0; src_sof = '1; src_eof = '1; dst_ready = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      src_valid = '1;
      #1;
      chk("R1 dst_valid", 32'(dst_valid), 0);
      chk("R1 src_ready", 32'(src_ready), 0);
      chk("R1 irq", 32'(irq), 0);
      rd_now(5'd0, r); chk("R1 ctrl", r, 0);
      rd_now(5'd1, r); chk("R1 status", r, 0);
      rd_now(5'd4, r); chk("R1 pick0", r, 0);
      src_valid = '0;

      // R2 run and enable
      wr(5'd0, 32'h3);
      rd_now(5'd0, r); chk("R2 ctrl readback", r, 3);
      @(negedge clk);
      rd_now(5'd1, r); chk("R2 status running", r, 1);

      // R11 unmapped words
      wr(5'd8, 32'h7);
      rd_now(5'd8, r); chk("R11 pick beyond sink count", r, 0);
      rd_now(5'd20, r); chk("R11 unmapped word", r, 0);
      rd_now(5'd3, r); chk("R11 commit word", r, 0);

      // table walk: R6 R7 R8
      for (int v = 0; v < 6; v++) begin
         src_valid = '0;
         for (int k = 0; k < NO; k++) wr(5'(4 + k), 32'(VEC[v][14 + 3*k +: 3]));
         wr(5'd3, 32'h1);
         @(negedge clk);
         src_valid = VEC[v][13:11];
         dst_ready = VEC[v][10:7];
         #1;
         chk($sformatf("R6 R7 R8 vec%0d dst_valid", v), 32'(dst_valid), 32'(VEC[v][6:3]));
         chk($sformatf("R7 R9 vec%0d src_ready", v), 32'(src_ready), 32'(VEC[v][2:0]));
         for (int k = 0; k < NO; k++) begin
            if (VEC[v][3 + k]) begin
               for (int i = 0; i < NI; i++)
                  if (VEC[v][14 + 3*k + i])
                     chk($sformatf("R6 vec%0d data sink%0d", v, k),
                         32'(dst_data[k*DW +: DW]), 32'(8'hA0 + i));
            end
         end
         @(negedge clk);
         src_valid = '0; dst_ready = '1;
      end

      // R5 clear, R3 staging
      wr(5'd2, 32'h1);
      chk("R5 irq cleared", 32'(irq), 0);
      wr(5'd4, 32'h1);
      wr(5'd5, 32'h4);
      src_valid = 3'b001;
      #1 chk("R3 staged pick not live", 32'(dst_valid[0]), 0);
      rd_now(5'd4, r); chk("R3 pick readback", r, 1);

      // R4 commit timing when idle
      wr(5'd3, 32'h1);
      #1 chk("R4 not live at first edge", 32'(dst_valid[0]), 0);
      @(negedge clk);
      #1;
      chk("R4 live at second edge", 32'(dst_valid[0]), 1);
      chk("R4 data", 32'(dst_data[7:0]), 32'h A0);
      chk("R5 irq raised", 32'(irq), 1);
      src_valid = '0;

      // R5 enable masking
      wr(5'd0, 32'h1);
      chk("R5 irq masked", 32'(irq), 0);
      rd_now(5'd2, r); chk("R5 status kept", r, 1);
      wr(5'd0, 32'h3);
      chk("R5 irq unmasked", 32'(irq), 1);
      wr(5'd2, 32'h1);
      rd_now(5'd2, r); chk("R5 status cleared", r, 0);

      // R4 deferral to frame end
      @(negedge clk);
      src_valid = 3'b001; src_sof = 3'b111; src_eof = 3'b110;
      #1 chk("R4 frame start", 32'(dst_valid[0]), 1);
      @(negedge clk);
      src_valid = '0;
      wr(5'd4, 32'h2);
      wr(5'd3, 32'h1);
      src_valid = 3'b111; src_sof = 3'b110; src_eof = 3'b000;
      #1;
      chk("R4 old route mid-frame valid", 32'(dst_valid[0]), 1);
      chk("R4 old route mid-frame data", 32'(dst_data[7:0]), 32'hA0);
      chk("R4 no new frame while pending", 32'(dst_valid[1]), 0);
      chk("R5 irq before boundary", 32'(irq), 0);
      @(negedge clk);
      src_eof = 3'b001;
      #1 chk("R4 end beat old data", 32'(dst_data[7:0]), 32'hA0);
      @(negedge clk);
      src_valid = 3'b110; src_eof = 3'b000;
      #1;
      chk("R5 irq not yet", 32'(irq), 0);
      chk("R4 old route idle", 32'(dst_valid[0]), 0);
      @(negedge clk);
      #1;
      chk("R4 new route valid", 32'(dst_valid[0]), 1);
      chk("R4 new route data", 32'(dst_data[7:0]), 32'hA1);
      chk("R5 irq at switch", 32'(irq), 1);
      chk("R4 new frames resume", 32'(dst_valid[1]), 1);
      src_valid = '0; src_sof = '1; src_eof = '1;

      // R9 drain vs hold
      wr(5'd16, 32'h1);
      rd_now(5'd16, r); chk("R9 drain readback", r, 1);
      src_valid = 3'b001;
      #1 chk("R9 drained source ready", 32'(src_ready[0]), 1);
      wr(5'd16, 32'h0);
      #1 chk("R9 held source not ready", 32'(src_ready[0]), 0);
      src_valid = '0;

      // R10 stop after frame
      @(negedge clk);
      src_valid = 3'b010; src_sof = 3'b111; src_eof = 3'b101;
      @(negedge clk);
      src_valid = '0;
      wr(5'd0, 32'h2);
      src_valid = 3'b110; src_sof = 3'b100; src_eof = 3'b010;
      #1;
      chk("R10 open frame continues", 32'(dst_valid[0]), 1);
      chk("R10 no new frame", 32'(dst_valid[1]), 0);
      rd_now(5'd1, r); chk("R10 still running", r, 1);
      @(negedge clk);
      src_valid = 3'b111;
      rd_now(5'd1, r); chk("R10 running one edge after end", r, 1);
      @(negedge clk);
      #1;
      rd_now(5'd1, r); chk("R10 stopped", r, 0);
      chk("R10 no ready when stopped", 32'(src_ready), 0);
      chk("R10 no valid when stopped", 32'(dst_valid), 0);
      src_valid = '0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule